// File: doc/BRIEF.md
# Serial Flash Command Arbiter

This block sits in a serial flash controller. It decides which of two command sources may drive the flash sequencer. The first source is a command trigger written through the peripheral register bus. The second source is a memory-mapped read request from the system bus, which carries a byte address.

For each new request the arbiter chooses one of four outcomes: start it now, hold it until the running command ends, drop it and raise a sticky error flag, or abort the running read and replace it. The rules are not symmetric:

- A system-bus read waits behind a register command.
- A register command is refused while a read is running.
- A newer read displaces an older read only when its address falls outside the 32-byte window that the older read is fetching.

The sequencer is seen through a small interface. The arbiter issues one-cycle start and abort pulses. It receives a level-sensitive busy signal and a one-cycle done pulse back. Three sticky flags report command completion and the two kinds of refused register command. Writing 1 to a flag bit clears that bit.

Top module: `flash_cmd_arbiter`

## Requirements
- R1: After reset, `seq_start`, `seq_abort` and `rd_stalled` are 0, and all three `flags` bits are 0.
- R2: When the block is idle, a register trigger produces `seq_start`=1 with `seq_is_read`=0 in the cycle after the trigger. If a read request arrives in the same cycle, the register command wins and the read is held (`rd_stalled`=1).
- R3: When the block is idle, a read request produces `seq_start`=1, `seq_is_read`=1 and `seq_addr` equal to the requested address, in the cycle after the request.
- R4: A register trigger while a register command runs does not start anything. It sets `flags[1]`.
- R5: A read request while a register command runs is held, with `rd_stalled`=1. A later request replaces the held address. When `seq_done` ends the register command, the held read starts in the next cycle with the latest held address.
- R6: A register trigger while a read is running, or while an aborted read is being wound down, causes no start and no abort. It sets `flags[2]`.
- R7: A read request whose address A satisfies base <= A < base+32, where base is the running read's start address, is absorbed. No abort and no start follow.
- R8: A read request outside that window produces a one-cycle `seq_abort` in the next cycle. The new read starts (`seq_start`=1, `seq_addr`=A) in the cycle after the first clock edge, following the abort pulse, at which `seq_busy` is sampled low.
- R9: `flags[0]` is set only by `seq_done` while a command is running. Ignored commands and aborted reads never set it.
- R10: Flags are sticky. Writing 1 to a bit of `flag_clr` clears that flag in the next cycle. A set event in the same cycle as a clear wins.
- R11: `seq_start` and `seq_abort` are never high together, and `seq_abort` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_cmd_vld | input | 1 | One-cycle register-bus command trigger |
| rd_req_vld | input | 1 | One-cycle memory-mapped read request |
| rd_req_addr | input | ADDR_W | Byte address of the read request |
| seq_busy | input | 1 | Sequencer is executing a command |
| seq_done | input | 1 | One-cycle pulse: running command completed |
| flag_clr | input | 3 | Write-1-to-clear for `flags` |
| seq_start | output | 1 | One-cycle start pulse to the sequencer |
| seq_is_read | output | 1 | Kind of the started command: 1 is read, 0 is register command |
| seq_addr | output | ADDR_W | Start address of the current read |
| seq_abort | output | 1 | One-cycle terminate pulse to the sequencer |
| rd_stalled | output | 1 | A read request is being held |
| flags | output | 3 | [0] done, [1] register-during-register, [2] register-during-read |

## Verification
Some properties are checked on every cycle by the assertions:
- start and abort are mutually exclusive, and an abort lasts one cycle and targets only a read;
- a register trigger during a read never produces an abort;
- no start occurs while a register command is still running;
- flags are sticky and their clears take effect;
- the done flag rises only after a completion pulse.

Other behaviour needs the bench's scenarios. The window boundaries are swept across offsets below, inside and beyond the 32-byte line. The bench also covers replacement of a held address, restart timing after the busy signal drops, and the set-beats-clear priority.

// File: rtl/fca_pkg.sv
package fca_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REG   = 2'd1,
    ST_RD    = 2'd2,
    ST_ABORT = 2'd3
  } fca_state_e;

  localparam int FLAG_DONE     = 0;
  localparam int FLAG_REG_COLL = 1;
  localparam int FLAG_REG_RD   = 2;
  localparam int NUM_FLAGS     = 3;
endpackage

// File: rtl/fca_window_hit.sv
module fca_window_hit #(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 32
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              hit
);
  localparam int EW = ADDR_W + 1;

  logic [EW-1:0] base_e;
  logic [EW-1:0] req_e;
  logic [EW-1:0] limit_e;

  always_comb begin
    base_e  = {1'b0, base_addr};
    req_e   = {1'b0, req_addr};
    limit_e = base_e + EW'(LINE_BYTES);
    hit     = (req_e >= base_e) && (req_e < limit_e);
  end
endmodule

// File: rtl/fca_flags.sv
module fca_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic en;
    logic nxt;

    always_comb begin
      en  = set[i] | clr[i];
      nxt = set[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  flag_q[i] <= 1'b0;
      else if (en) flag_q[i] <= nxt;
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !clr[i]) |=> flag_q[i]);                 // R10
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !flag_q[i]);                   // R10
  end
endmodule

// File: rtl/fca_ctrl.sv
module fca_ctrl
  import fca_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_cmd_vld,
  input  logic              rd_req_vld,
  input  logic [ADDR_W-1:0] rd_req_addr,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic              rd_hit,
  output logic [ADDR_W-1:0] base_q,
  output logic              seq_start,
  output logic              seq_is_read,
  output logic              seq_abort,
  output logic              rd_stalled,
  output logic              set_done,
  output logic              set_reg_coll,
  output logic              set_reg_rd
);
  fca_state_e        st_q, st_n;
  logic              pend_q, pend_n;
  logic [ADDR_W-1:0] pend_addr_q, pend_addr_n;
  logic [ADDR_W-1:0] base_n;
  logic              start_n, is_read_n, abort_n;
  logic [ADDR_W-1:0] held_addr;

  always_comb begin
    st_n         = st_q;
    pend_n       = pend_q;
    pend_addr_n  = pend_addr_q;
    base_n       = base_q;
    start_n      = 1'b0;
    is_read_n    = seq_is_read;
    abort_n      = 1'b0;
    set_done     = 1'b0;
    set_reg_coll = 1'b0;
    set_reg_rd   = 1'b0;
    held_addr    = rd_req_vld ? rd_req_addr : pend_addr_q;

    case (st_q)
      ST_IDLE: begin
        if (reg_cmd_vld) begin
          start_n   = 1'b1;
          is_read_n = 1'b0;
          st_n      = ST_REG;
          if (rd_req_vld) begin
            pend_n      = 1'b1;
            pend_addr_n = rd_req_addr;
          end
        end else if (rd_req_vld) begin
          start_n   = 1'b1;
          is_read_n = 1'b1;
          base_n    = rd_req_addr;
          st_n      = ST_RD;
        end
      end
      ST_REG: begin
        set_reg_coll = reg_cmd_vld;
        if (rd_req_vld) begin
          pend_n      = 1'b1;
          pend_addr_n = rd_req_addr;
        end
        if (seq_done) begin
          set_done = 1'b1;
          if (pend_q || rd_req_vld) begin
            start_n   = 1'b1;
            is_read_n = 1'b1;
            base_n    = held_addr;
            pend_n    = 1'b0;
            st_n      = ST_RD;
          end else begin
            st_n = ST_IDLE;
          end
        end
      end
      ST_RD: begin
        set_reg_rd = reg_cmd_vld;
        if (seq_done) begin
          set_done = 1'b1;
          if (rd_req_vld) begin
            start_n   = 1'b1;
            is_read_n = 1'b1;
            base_n    = rd_req_addr;
          end else begin
            st_n = ST_IDLE;
          end
        end else if (rd_req_vld && !rd_hit) begin
          abort_n     = 1'b1;
          pend_n      = 1'b1;
          pend_addr_n = rd_req_addr;
          st_n        = ST_ABORT;
        end
      end
      ST_ABORT: begin
        set_reg_rd = reg_cmd_vld;
        if (rd_req_vld) pend_addr_n = rd_req_addr;
        if (!seq_abort && !seq_busy) begin
          start_n   = 1'b1;
          is_read_n = 1'b1;
          base_n    = held_addr;
          pend_n    = 1'b0;
          st_n      = ST_RD;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      base_q      <= '0;
      seq_start   <= 1'b0;
      seq_is_read <= 1'b0;
      seq_abort   <= 1'b0;
    end else begin
      st_q        <= st_n;
      pend_q      <= pend_n;
      pend_addr_q <= pend_addr_n;
      base_q      <= base_n;
      seq_start   <= start_n;
      seq_is_read <= is_read_n;
      seq_abort   <= abort_n;
    end
  end

  assign rd_stalled = pend_q;

  AST_START_ABORT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_start && seq_abort));                                        // R11
  AST_ABORT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |=> !seq_abort);                                         // R11
  AST_ABORT_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    seq_abort |-> seq_is_read);                                        // R8
  AST_REG_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RD && reg_cmd_vld && !rd_req_vld) |=> !seq_abort);     // R6
  AST_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_REG && !seq_done) |=> !seq_start);                     // R5
endmodule

// File: rtl/flash_cmd_arbiter.sv
module flash_cmd_arbiter
  import fca_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int LINE_BYTES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_cmd_vld,
  input  logic                 rd_req_vld,
  input  logic [ADDR_W-1:0]    rd_req_addr,
  input  logic                 seq_busy,
  input  logic                 seq_done,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  output logic                 seq_start,
  output logic                 seq_is_read,
  output logic [ADDR_W-1:0]    seq_addr,
  output logic                 seq_abort,
  output logic                 rd_stalled,
  output logic [NUM_FLAGS-1:0] flags
);
  logic [1:0]           rst_sync_q;
  logic                 core_rst_n;
  logic                 hit;
  logic [ADDR_W-1:0]    base;
  logic                 set_done, set_reg_coll, set_reg_rd;
  logic [NUM_FLAGS-1:0] flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  fca_window_hit #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_hit (
    .base_addr (base),
    .req_addr  (rd_req_addr),
    .hit       (hit)
  );

  fca_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (core_rst_n),
    .reg_cmd_vld  (reg_cmd_vld),
    .rd_req_vld   (rd_req_vld),
    .rd_req_addr  (rd_req_addr),
    .seq_busy     (seq_busy),
    .seq_done     (seq_done),
    .rd_hit       (hit),
    .base_q       (base),
    .seq_start    (seq_start),
    .seq_is_read  (seq_is_read),
    .seq_abort    (seq_abort),
    .rd_stalled   (rd_stalled),
    .set_done     (set_done),
    .set_reg_coll (set_reg_coll),
    .set_reg_rd   (set_reg_rd)
  );

  always_comb begin
    flag_set                = '0;
    flag_set[FLAG_DONE]     = set_done;
    flag_set[FLAG_REG_COLL] = set_reg_coll;
    flag_set[FLAG_REG_RD]   = set_reg_rd;
  end

  fca_flags #(.N(NUM_FLAGS)) u_flags (
    .clk    (clk),
    .rst_n  (core_rst_n),
    .set    (flag_set),
    .clr    (flag_clr),
    .flag_q (flags)
  );

  assign seq_addr = base;

  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!core_rst_n)
    $rose(flags[FLAG_DONE]) |-> $past(seq_done));                      // R9
endmodule

// File: tb/sim_flash_cmd_arbiter.sv
module sim_flash_cmd_arbiter;
  localparam int CLK_P = 10;
  localparam int AW    = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_cmd_vld, rd_req_vld, seq_busy, seq_done;
  logic [AW-1:0] rd_req_addr;
  logic [2:0]    flag_clr;
  logic          seq_start, seq_is_read, seq_abort, rd_stalled;
  logic [AW-1:0] seq_addr;
  logic [2:0]    flags;

  int errors = 0;
  int checks = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_cmd_arbiter #(.ADDR_W(AW), .LINE_BYTES(32)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_cmd_vld(reg_cmd_vld), .rd_req_vld(rd_req_vld),
    .rd_req_addr(rd_req_addr), .seq_busy(seq_busy), .seq_done(seq_done),
    .flag_clr(flag_clr), .seq_start(seq_start), .seq_is_read(seq_is_read),
    .seq_addr(seq_addr), .seq_abort(seq_abort), .rd_stalled(rd_stalled), .flags(flags)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock edge, then back to the falling edge, pulse inputs dropped
  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    reg_cmd_vld = 1'b0;
    rd_req_vld  = 1'b0;
    seq_done    = 1'b0;
    flag_clr    = '0;
  endtask

  task automatic finish_cmd();
    seq_done = 1'b1;
    cyc();
    seq_busy = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_cmd_vld = 0; rd_req_vld = 0; rd_req_addr = '0;
    seq_busy = 0; seq_done = 0; flag_clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 start", int'(seq_start), 0);
    chk("R1 abort", int'(seq_abort), 0);
    chk("R1 stalled", int'(rd_stalled), 0);
    chk("R1 flags", int'(flags), 0);

    // R2 register wins over simultaneous read
    reg_cmd_vld = 1; rd_req_vld = 1; rd_req_addr = 16'h0100;
    cyc();
    chk("R2 start", int'(seq_start), 1);
    chk("R2 kind", int'(seq_is_read), 0);
    chk("R2 stalled", int'(rd_stalled), 1);
    seq_busy = 1;

    // R4 register during register
    reg_cmd_vld = 1;
    cyc();
    chk("R4 no start", int'(seq_start), 0);
    chk("R4 flag1", int'(flags[1]), 1);
    chk("R9 ignored no done", int'(flags[0]), 0);

    // R5 replacement of held address, start after done
    rd_req_vld = 1; rd_req_addr = 16'h0200;
    cyc();
    chk("R5 stalled", int'(rd_stalled), 1);
    chk("R5 held no start", int'(seq_start), 0);
    finish_cmd();
    chk("R5 start", int'(seq_start), 1);
    chk("R5 kind", int'(seq_is_read), 1);
    chk("R5 addr", int'(seq_addr), 16'h0200);
    chk("R5 stall gone", int'(rd_stalled), 0);
    chk("R9 done flag", int'(flags[0]), 1);
    seq_busy = 1;

    // R10 clear
    flag_clr = 3'b011;
    cyc();
    chk("R10 cleared", int'(flags), 0);

    // R6 register during read
    reg_cmd_vld = 1;
    cyc();
    chk("R6 no start", int'(seq_start), 0);
    chk("R6 no abort", int'(seq_abort), 0);
    chk("R6 flag2", int'(flags[2]), 1);

    // R10 set wins over clear
    reg_cmd_vld = 1; flag_clr = 3'b100;
    cyc();
    chk("R10 set wins", int'(flags[2]), 1);
    flag_clr = 3'b100;
    cyc();
    chk("R10 clear alone", int'(flags[2]), 0);
    finish_cmd();
    chk("R9 read done", int'(flags[0]), 1);
    flag_clr = 3'b001;
    cyc();

    // R3 R7 R8 sweep around the fetch window
    for (int off = -40; off <= 44; off += 4) begin
      automatic logic [AW-1:0] base = 16'h0400;
      automatic logic [AW-1:0] na   = AW'(32'h400 + off);
      automatic bit hit = (off >= 0) && (off < 32);
      rd_req_vld = 1; rd_req_addr = base;
      cyc();
      chk("R3 start", int'(seq_start), 1);
      chk("R3 addr", int'(seq_addr), int'(base));
      seq_busy = 1;
      rd_req_vld = 1; rd_req_addr = na;
      cyc();
      chk(hit ? "R7 absorbed" : "R8 abort", int'(seq_abort), hit ? 0 : 1);
      chk("R11 no start with req", int'(seq_start), 0);
      if (!hit) begin
        reg_cmd_vld = 1;
        cyc();
        chk("R11 abort one cycle", int'(seq_abort), 0);
        chk("R8 wait busy", int'(seq_start), 0);
        chk("R6 flag2 in abort", int'(flags[2]), 1);
        seq_busy = 0;
        cyc();
        chk("R8 restart", int'(seq_start), 1);
        chk("R8 new addr", int'(seq_addr), int'(na));
        chk("R9 abort no done", int'(flags[0]), 0);
        seq_busy = 1;
      end
      finish_cmd();
      chk("R9 done", int'(flags[0]), 1);
      flag_clr = 3'b111;
      cyc();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule